// File: doc/BRIEF.md
# Digital silence detector with noise test output

This block watches a stereo sample stream one frame at a time. Each frame is marked by a one-cycle sample-valid strobe that comes with a left and a right sample. A saturating counter tracks how many frames in a row have carried zero on both channels. Once that run reaches the silence threshold, 1024 frames by default, a silence indication goes high. It can drive an external muting stage during digital silence.

The same block holds a maximal-length pseudo-random bit generator. The generator advances one bit for each pulse of a bit-rate enable, which runs at 128 times the sample rate. A test code input chooses what the flag pin carries. The code value 7 puts the noise bitstream on the pin, and every other code gives the silence indication. The raw silence indication and the raw noise bit are also brought out, whatever the test code.

Top module: `quiet_flag_gen`

## Requirements
- R1: After reset the silence counter is zero and `silent_raw` and `zero_flag` are low. The noise register holds the nonzero seed (default 24'hACE1B5), so `noise_bit` equals the seed's most significant bit.
- R2: `silent_raw` goes high in the cycle after the strobe that delivers the 1024th frame in a row with both samples equal to zero. After 1023 such frames it is still low.
- R3: A strobed frame with a nonzero sample on either channel clears the counter. `silent_raw` is then low in the next cycle.
- R4: The counter saturates at 1024 and does not wrap. Further all-zero frames keep `silent_raw` high however many arrive.
- R5: Cycles with `smp_vld` low change neither the counter nor `silent_raw`, whatever values the sample inputs carry.
- R6: The noise register shifts exactly once in each cycle where `noise_en` is high, and holds in every other cycle.
- R7: The noise register is a 24-bit Fibonacci shift register that shifts toward its most significant bit. The new bit 0 is the XOR of bits 23, 22, 21 and 16, which are taps 24, 23, 22 and 17. `noise_bit` is bit 23, and the period is 2^24 − 1.
- R8: When `test_code` equals 7, `zero_flag` carries `noise_bit`. For any other value, including 6, 8, 135 and 255, `zero_flag` carries `silent_raw`.
- R9: `silent_raw` and `noise_bit` do not depend on `test_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | One-cycle frame strobe qualifying the samples |
| smp_left | input | 24 | Left channel sample, two's complement |
| smp_right | input | 24 | Right channel sample, two's complement |
| noise_en | input | 1 | Bit-rate enable (128 × sample rate) for the noise generator |
| test_code | input | 8 | Test register value; 7 selects noise on the flag pin |
| zero_flag | output | 1 | Flag pin: silence indication or noise bitstream |
| silent_raw | output | 1 | Silence indication before the test selection |
| noise_bit | output | 1 | Current noise generator output bit |

## Verification
The detector is first given 1023 and then 1024 all-zero frames, which pins the threshold to a single frame. A long run of about 1500 more zero frames shows that the counter saturates and does not wrap back to low. Every non-strobe cycle carries nonzero garbage samples, which separates strobe-qualified counting from sampling on every clock. Frames that are nonzero on only the left channel or only the right channel show that either channel alone breaks silence. Enable pulses on a sparse pattern, together with sweeps of the test code through 7, 6, 8, 135 and 255, separate the shift-register taps, the advance-only-on-enable rule, and an exact code match from a partial bit match.

// File: rtl/quiet_flag_pkg.sv
package quiet_flag_pkg;

   typedef enum logic {
      SRC_SILENCE = 1'b0,
      SRC_NOISE   = 1'b1
   } flag_src_e;

   // Feedback mask of a maximal-length Fibonacci register for supported widths
   function automatic logic [31:0] tap_mask(input int width);
      case (width)
         16:      return 32'h0000_D008;
         24:      return 32'h00E1_0000;
         32:      return 32'h8020_0003;
         default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic bit width_supported(input int width);
      return (width == 16) || (width == 24) || (width == 32);
   endfunction

endpackage

// File: rtl/quiet_frame_counter.sv
module quiet_frame_counter #(
   parameter int SAMPLE_W = 24,
   parameter int LIMIT    = 1024,
   localparam int CNT_W   = $clog2(LIMIT + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vld,
   input  logic [SAMPLE_W-1:0] left_s,
   input  logic [SAMPLE_W-1:0] right_s,
   output logic [CNT_W-1:0]    cnt,
   output logic                silent
);

   localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("quiet_frame_counter: LIMIT must be at least 1");
   end
   if (SAMPLE_W < 1) begin : g_bad_width
      $error("quiet_frame_counter: SAMPLE_W must be at least 1");
   end

   logic             both_zero;
   logic [CNT_W-1:0] cnt_q;

   assign both_zero = (left_s == '0) && (right_s == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (vld) begin
         if (!both_zero) begin
            cnt_q <= '0;
         end else if (cnt_q != LIMIT_V) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt    = cnt_q;
   assign silent = (cnt_q == LIMIT_V);

endmodule

// File: rtl/quiet_noise_lfsr.sv
module quiet_noise_lfsr #(
   parameter int           W    = 24,
   parameter logic [W-1:0] SEED = W'(24'hACE1B5)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic bit_o
);

   localparam logic [31:0]  TAPS_FULL = quiet_flag_pkg::tap_mask(W);
   localparam logic [W-1:0] TAPS      = TAPS_FULL[W-1:0];

   if (!quiet_flag_pkg::width_supported(W)) begin : g_bad_w
      $error("quiet_noise_lfsr: width %0d has no tap set", W);
   end
   if (SEED == '0) begin : g_bad_seed
      $error("quiet_noise_lfsr: SEED must be nonzero");
   end

   logic [W-1:0] state_q;
   logic         fb;

   assign fb = ^(state_q & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEED;
      end else if (step) begin
         state_q <= {state_q[W-2:0], fb};
      end
   end

   assign bit_o = state_q[W-1];

endmodule

// File: rtl/quiet_pin_select.sv
module quiet_pin_select #(
   parameter int               TEST_W     = 8,
   parameter logic [TEST_W-1:0] NOISE_CODE = TEST_W'(7),
   parameter bit               REG_PIN    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEST_W-1:0] code,
   input  logic              silent,
   input  logic              noise,
   output logic              pin
);

   import quiet_flag_pkg::*;

   flag_src_e src;
   logic      pin_d;

   assign src   = (code == NOISE_CODE) ? SRC_NOISE : SRC_SILENCE;
   assign pin_d = (src == SRC_NOISE) ? noise : silent;

   if (REG_PIN) begin : g_reg
      logic pin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_q <= 1'b0;
         else        pin_q <= pin_d;
      end
      assign pin = pin_q;
   end else begin : g_comb
      assign pin = pin_d;
   end

endmodule

// File: rtl/quiet_flag_gen.sv
module quiet_flag_gen #(
   parameter int                 SAMPLE_W   = 24,
   parameter int                 LIMIT      = 1024,
   parameter int                 LFSR_W     = 24,
   parameter logic [LFSR_W-1:0]  SEED       = LFSR_W'(24'hACE1B5),
   parameter int                 TEST_W     = 8,
   parameter logic [TEST_W-1:0]  NOISE_CODE = TEST_W'(7),
   parameter bit                 REG_PIN    = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_vld,
   input  logic [SAMPLE_W-1:0] smp_left,
   input  logic [SAMPLE_W-1:0] smp_right,
   input  logic                noise_en,
   input  logic [TEST_W-1:0]   test_code,
   output logic                zero_flag,
   output logic                silent_raw,
   output logic                noise_bit
);

   localparam int CNT_W = $clog2(LIMIT + 1);

   if (TEST_W < 1) begin : g_bad_test_w
      $error("quiet_flag_gen: TEST_W must be at least 1");
   end

   logic [CNT_W-1:0] frame_cnt;
   logic             silent_w;
   logic             noise_w;

   quiet_frame_counter #(
      .SAMPLE_W (SAMPLE_W),
      .LIMIT    (LIMIT)
   ) u_frames (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (smp_vld),
      .left_s  (smp_left),
      .right_s (smp_right),
      .cnt     (frame_cnt),
      .silent  (silent_w)
   );

   quiet_noise_lfsr #(
      .W    (LFSR_W),
      .SEED (SEED)
   ) u_noise (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (noise_en),
      .bit_o (noise_w)
   );

   quiet_pin_select #(
      .TEST_W     (TEST_W),
      .NOISE_CODE (NOISE_CODE),
      .REG_PIN    (REG_PIN)
   ) u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .code   (test_code),
      .silent (silent_w),
      .noise  (noise_w),
      .pin    (zero_flag)
   );

   assign silent_raw = silent_w;
   assign noise_bit  = noise_w;

endmodule

// File: rtl/quiet_flag_chk.sv
module quiet_flag_chk #(
   parameter int                SAMPLE_W   = 24,
   parameter int                LIMIT      = 1024,
   parameter int                TEST_W     = 8,
   parameter logic [TEST_W-1:0] NOISE_CODE = TEST_W'(7),
   parameter bit                REG_PIN    = 1'b0,
   localparam int               CNT_W      = $clog2(LIMIT + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                smp_vld,
   input logic [SAMPLE_W-1:0] smp_left,
   input logic [SAMPLE_W-1:0] smp_right,
   input logic                noise_en,
   input logic [TEST_W-1:0]   test_code,
   input logic                zero_flag,
   input logic                silent_raw,
   input logic                noise_bit,
   input logic [CNT_W-1:0]    frame_cnt
);

   logic zero_frame;
   logic live_frame;
   assign zero_frame = smp_vld && (smp_left == '0) && (smp_right == '0);
   assign live_frame = smp_vld && ((smp_left != '0) || (smp_right != '0));

   AST_RISE_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $rose(silent_raw) |-> $past(zero_frame)); // R2
   AST_LIVE_DROPS: assert property (@(posedge clk) disable iff (!rst_n) live_frame |=> !silent_raw); // R3
   AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (silent_raw && zero_frame) |=> silent_raw); // R4
   AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n) frame_cnt <= CNT_W'(LIMIT)); // R4
   AST_IDLE_FRAME: assert property (@(posedge clk) disable iff (!rst_n) !smp_vld |=> ($stable(silent_raw) && $stable(frame_cnt))); // R5
   AST_NOISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !noise_en |=> $stable(noise_bit)); // R6

   if (!REG_PIN) begin : g_pin_chk
      AST_PIN_SILENCE: assert property (@(posedge clk) disable iff (!rst_n) (test_code != NOISE_CODE) |-> (zero_flag == silent_raw)); // R8
      AST_PIN_NOISE: assert property (@(posedge clk) disable iff (!rst_n) (test_code == NOISE_CODE) |-> (zero_flag == noise_bit)); // R8
   end

endmodule

bind quiet_flag_gen quiet_flag_chk #(
   .SAMPLE_W   (SAMPLE_W),
   .LIMIT      (LIMIT),
   .TEST_W     (TEST_W),
   .NOISE_CODE (NOISE_CODE),
   .REG_PIN    (REG_PIN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_vld    (smp_vld),
   .smp_left   (smp_left),
   .smp_right  (smp_right),
   .noise_en   (noise_en),
   .test_code  (test_code),
   .zero_flag  (zero_flag),
   .silent_raw (silent_raw),
   .noise_bit  (noise_bit),
   .frame_cnt  (frame_cnt)
);

// File: tb/quiet_flag_gen_bench.sv
module quiet_flag_gen_bench;

   localparam int          SW   = 24;
   localparam int          LIM  = 1024;
   localparam logic [23:0] SEED = 24'hACE1B5;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic          vld   = 1'b0;
   logic          nen   = 1'b0;
   logic [SW-1:0] l_s   = '0;
   logic [SW-1:0] r_s   = '0;
   logic [7:0]    tst   = 8'd0;
   logic          zf, sr, nb;

   always #10 clk = ~clk;

   quiet_flag_gen u_quiet_flag_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_vld    (vld),
      .smp_left   (l_s),
      .smp_right  (r_s),
      .noise_en   (nen),
      .test_code  (tst),
      .zero_flag  (zf),
      .silent_raw (sr),
      .noise_bit  (nb)
   );

   int          checks   = 0;
   int          errors   = 0;
   int          run_m    = 0;
   logic [23:0] lf_m     = SEED;
   int          cyc      = 0;
   bit          noise_on = 1'b0;
   bit          done     = 1'b0;

   // Behavioural reference: zero-frame run length and noise register
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_m = 0;
         lf_m  = SEED;
      end else begin
         if (vld) begin
            if (l_s == 0 && r_s == 0) begin
               if (run_m < LIM) run_m = run_m + 1;
            end else begin
               run_m = 0;
            end
         end
         if (nen) lf_m = {lf_m[22:0], lf_m[23] ^ lf_m[22] ^ lf_m[21] ^ lf_m[16]};
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic exp_sil, exp_nb, exp_pin;
      exp_sil = (run_m == LIM);
      exp_nb  = lf_m[23];
      exp_pin = (tst == 8'd7) ? exp_nb : exp_sil;
      chk((tst == 8'd7) ? "R9 silent" : "R2 silent", sr, exp_sil);
      chk("R6 R7 noise", nb, exp_nb);
      chk("R8 pin", zf, exp_pin);
   endtask

   task automatic step(input logic v, input logic [SW-1:0] a, input logic [SW-1:0] b);
      @(negedge clk);
      compare_all();
      cyc++;
      vld = v;
      l_s = a;
      r_s = b;
      nen = noise_on && ((cyc % 3) == 0);
   endtask

   // One strobed frame, then one idle cycle with garbage samples
   task automatic frames(input int n, input logic [SW-1:0] a, input logic [SW-1:0] b);
      for (int i = 0; i < n; i++) begin
         step(1'b1, a, b);
         step(1'b0, 24'h123456, 24'h800001);
      end
   endtask

   initial begin
      logic held;
      repeat (3) @(negedge clk);
      chk("R1 silent", sr, 1'b0);
      chk("R1 pin", zf, 1'b0);
      chk("R1 noise", nb, SEED[23]);
      rst_n = 1'b1;

      frames(LIM - 1, '0, '0);
      chk("R2 before threshold", sr, 1'b0);
      frames(1, '0, '0);
      chk("R2 at threshold", sr, 1'b1);

      frames(1500, '0, '0);
      chk("R4 saturated", sr, 1'b1);

      for (int i = 0; i < 10; i++) step(1'b0, 24'h7FFFFF, 24'h000001);
      chk("R5 idle frames ignored", sr, 1'b1);

      frames(1, '0, 24'h000001);
      chk("R3 right nonzero", sr, 1'b0);
      frames(LIM, '0, '0);
      chk("R2 recount", sr, 1'b1);
      frames(1, 24'hFFFFFF, '0);
      chk("R3 left nonzero", sr, 1'b0);
      frames(LIM - 1, '0, '0);
      chk("R3 counter cleared", sr, 1'b0);

      held = nb;
      for (int i = 0; i < 12; i++) step(1'b0, '0, '0);
      chk("R6 hold without enable", nb, held);

      noise_on = 1'b1;
      tst = 8'd7;
      for (int i = 0; i < 300; i++) step(1'b0, '0, '0);
      frames(1, '0, '0);
      chk("R9 silent under test code", sr, 1'b1);
      chk("R8 noise on pin", zf, nb);
      for (int i = 0; i < 60; i++) step(1'b0, '0, '0);

      tst = 8'd6;
      step(1'b0, '0, '0);
      chk("R8 code 6", zf, sr);
      tst = 8'd8;
      step(1'b0, '0, '0);
      chk("R8 code 8", zf, sr);
      tst = 8'd135;
      step(1'b0, '0, '0);
      chk("R8 code 135", zf, sr);
      tst = 8'd255;
      for (int i = 0; i < 40; i++) step(1'b0, '0, '0);
      chk("R8 code 255", zf, 1'b1);

      step(1'b0, '0, '0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule